// File: doc/BRIEF.md
# Per-Port Event Statistics Counter Bank

This block counts events for every port of a multi-port switch. Each port brings in one single-cycle pulse line per statistic. Every pulse adds one to a 16-bit counter that belongs to that line. The counters wrap silently. Each wrap is remembered twice: once in a per-counter overflow flag and once in a pending interrupt bit for the port. Software can therefore widen any count past 16 bits by adding 65536 for each overflow it collects.

Software reaches the bank through a small synchronous word-addressed register bus, and reads take no wait states. A write to the control word selects a port and a counter group and takes a snapshot into two data words. One data word holds the low bytes and the other holds the high bytes, with four counters side by side in byte lanes. The same control word can instead fetch the port's overflow flags, and that fetch also clears them. Three interrupt registers manage the per-port pending bits: one sets enables, one clears enables, and one reads and acknowledges pending bits. A single interrupt line is the OR of every pending bit that is also enabled.

Top module: `stats_bank`

## Requirements
- R1: Each pulse on line `p*NCNT+c` of `ev_i` adds one to counter c of port p at the next clock edge. Each counter is 16 bits wide.
- R2: A pulse that arrives while a counter holds 0xFFFF takes it to 0x0000 and sets that counter's overflow flag.
- R3: A write to word 0 with bit 0 set and bit 1 clear takes a snapshot of port `wdata[15:8]` and group `wdata[7:4]`. In word 1, lane i (bits 8i+7..8i) then holds the low byte of counter 4*group+i, using the values from before that edge. In word 2, the same lane holds that counter's high byte.
- R4: Snapshot lanes that name no counter read as zero. This covers lanes 1 to 3 of group 4, any group above 4, and any port number at or above NPORTS.
- R5: A write to word 0 with bit 1 set loads word 1 with the selected port's overflow flags (bit n for counter n) and loads word 2 with zero. This takes precedence over bit 0. The same write clears that port's flags, except that a wrap in the same cycle leaves its flag set.
- R6: Words 1 and 2 change only on such control writes. Counters keep counting while a snapshot is held.
- R7: A wrap of any counter on port p sets pending bit p, which can be read in word 5.
- R8: Writing ones to word 3 enables those port interrupts, and word 3 reads back the enable mask. Writing ones to word 4 disables them. Writing ones to word 5 clears those pending bits, but a wrap in the same cycle wins over the clear.
- R9: `irq_o` is high exactly when some pending bit is also enabled.
- R10: After reset, all counters, flags, pending bits, enables and data words are zero, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | NPORTS*NCNT | Event pulses, line p*NCNT+c feeds counter c of port p |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, available in the same cycle |
| irq_o | output | 1 | OR of the enabled pending bits |

## Verification
The bench drives counters to 0xFFFF and then wraps them. A design with the wrong wrap width or without a flag would miss the overflow and would leave the interrupt quiet. It fetches flags in the same cycle that a fresh wrap arrives, and it clears pending bits in the same cycle that a wrap arrives. Either collision would lose an event if the clear took priority. It also reads group 4, groups that do not exist and ports that do not exist, which exposes lanes that alias other counters. Random traffic runs during held snapshots, so it catches a data word that tracks the live counters, and it catches a snapshot taken one edge late.

// File: rtl/stats_pkg.sv
package stats_pkg;
    localparam int DATA_W        = 32;
    localparam int LANES         = 4;
    localparam int LANE_W        = 8;
    localparam int CTRL_RDEN_BIT = 0;
    localparam int CTRL_OVF_BIT  = 1;
    localparam int CTRL_GRP_LSB  = 4;
    localparam int CTRL_GRP_W    = 4;
    localparam int CTRL_PORT_LSB = 8;
    localparam int CTRL_PORT_W   = 8;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_LO    = 3'd1,
        REG_HI    = 3'd2,
        REG_IEN   = 3'd3,
        REG_IDIS  = 3'd4,
        REG_ISTAT = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/stats_port_cnt.sv
module stats_port_cnt #(
    parameter int NCNT  = 17,
    parameter int CNT_W = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NCNT-1:0]       ev_i,
    input  logic                  flag_clr_i,
    output logic [NCNT*CNT_W-1:0] cnt_o,
    output logic [NCNT-1:0]       flags_o,
    output logic [NCNT-1:0]       wrap_o
);
    typedef struct packed {
        logic [NCNT-1:0][CNT_W-1:0] cnt;
        logic [NCNT-1:0]            flg;
    } pc_state_t;

    pc_state_t st_d, st_q;
    logic [NCNT-1:0] wrap_d;

    always_comb begin
        st_d   = st_q;
        wrap_d = '0;
        for (int i = 0; i < NCNT; i++) begin
            if (ev_i[i]) begin
                wrap_d[i]     = (st_q.cnt[i] == {CNT_W{1'b1}});
                st_d.cnt[i]   = st_q.cnt[i] + 1'b1;
            end
        end
        // a wrap in the clearing cycle survives the clear
        st_d.flg = (flag_clr_i ? '0 : st_q.flg) | wrap_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign flags_o = st_q.flg;
    assign wrap_o  = wrap_d;
endmodule

// File: rtl/stats_lane_pick.sv
module stats_lane_pick
    import stats_pkg::*;
#(
    parameter int NPORTS = 18,
    parameter int NCNT   = 17,
    parameter int CNT_W  = 16
) (
    input  logic [NPORTS*NCNT*CNT_W-1:0] cnt_all_i,
    input  logic [CTRL_PORT_W-1:0]       port_i,
    input  logic [CTRL_GRP_W-1:0]        grp_i,
    output logic [DATA_W-1:0]            lo_o,
    output logic [DATA_W-1:0]            hi_o
);
    logic [CNT_W-1:0] word;

    always_comb begin
        lo_o = '0;
        hi_o = '0;
        word = '0;
        for (int p = 0; p < NPORTS; p++) begin
            for (int c = 0; c < NCNT; c++) begin
                if (port_i == CTRL_PORT_W'(p) && grp_i == CTRL_GRP_W'(c / LANES)) begin
                    word = cnt_all_i[(p*NCNT + c)*CNT_W +: CNT_W];
                    lo_o[(c % LANES)*LANE_W +: LANE_W] = word[LANE_W-1:0];
                    hi_o[(c % LANES)*LANE_W +: LANE_W] = word[2*LANE_W-1:LANE_W];
                end
            end
        end
    end
endmodule

// File: rtl/stats_irq.sv
module stats_irq #(
    parameter int NPORTS = 18
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NPORTS-1:0] set_i,
    input  logic [NPORTS-1:0] en_set_i,
    input  logic [NPORTS-1:0] en_clr_i,
    input  logic [NPORTS-1:0] ack_i,
    output logic [NPORTS-1:0] pend_o,
    output logic [NPORTS-1:0] en_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NPORTS-1:0] pend;
        logic [NPORTS-1:0] en;
        logic              irq;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~ack_i) | set_i;
        st_d.en   = (st_q.en | en_set_i) & ~en_clr_i;
        st_d.irq  = |(st_d.pend & st_d.en);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/stats_bank.sv
module stats_bank
    import stats_pkg::*;
#(
    parameter int NPORTS = 18,
    parameter int NCNT   = 17
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NPORTS*NCNT-1:0] ev_i,
    input  logic                   bus_wr_i,
    input  logic [2:0]             bus_addr_i,
    input  logic [DATA_W-1:0]      bus_wdata_i,
    output logic [DATA_W-1:0]      bus_rdata_o,
    output logic                   irq_o
);
    localparam int CNT_W = 2 * LANE_W;
    localparam int TOT_W = NPORTS * NCNT * CNT_W;

    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
    } snap_t;

    snap_t snap_d, snap_q;

    logic [TOT_W-1:0]             cnt_all;
    logic [NPORTS-1:0][NCNT-1:0]  flags_all;
    logic [NPORTS*NCNT-1:0]       wrap_all;
    logic [NPORTS-1:0]            wrap_port;
    logic [NPORTS-1:0]            flag_clr;
    logic [NPORTS-1:0]            pend, en;
    logic [NCNT-1:0]              sel_flags;
    logic [DATA_W-1:0]            pick_lo, pick_hi;
    logic [CTRL_PORT_W-1:0]       sel_port;
    logic [CTRL_GRP_W-1:0]        sel_grp;
    logic [NPORTS-1:0]            wmask;
    logic                         wr_ctrl, wr_ien, wr_idis, wr_ack;

    assign sel_port = bus_wdata_i[CTRL_PORT_LSB +: CTRL_PORT_W];
    assign sel_grp  = bus_wdata_i[CTRL_GRP_LSB +: CTRL_GRP_W];
    assign wmask    = bus_wdata_i[NPORTS-1:0];
    assign wr_ctrl  = bus_wr_i && (bus_addr_i == REG_CTRL);
    assign wr_ien   = bus_wr_i && (bus_addr_i == REG_IEN);
    assign wr_idis  = bus_wr_i && (bus_addr_i == REG_IDIS);
    assign wr_ack   = bus_wr_i && (bus_addr_i == REG_ISTAT);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign flag_clr[p] = wr_ctrl && bus_wdata_i[CTRL_OVF_BIT]
                             && (sel_port == CTRL_PORT_W'(p));

        stats_port_cnt #(.NCNT(NCNT), .CNT_W(CNT_W)) u_cnt (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .ev_i       (ev_i[p*NCNT +: NCNT]),
            .flag_clr_i (flag_clr[p]),
            .cnt_o      (cnt_all[p*NCNT*CNT_W +: NCNT*CNT_W]),
            .flags_o    (flags_all[p]),
            .wrap_o     (wrap_all[p*NCNT +: NCNT])
        );

        assign wrap_port[p] = |wrap_all[p*NCNT +: NCNT];
    end

    stats_lane_pick #(.NPORTS(NPORTS), .NCNT(NCNT), .CNT_W(CNT_W)) u_pick (
        .cnt_all_i (cnt_all),
        .port_i    (sel_port),
        .grp_i     (sel_grp),
        .lo_o      (pick_lo),
        .hi_o      (pick_hi)
    );

    stats_irq #(.NPORTS(NPORTS)) u_irq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (wrap_port),
        .en_set_i (wr_ien  ? wmask : '0),
        .en_clr_i (wr_idis ? wmask : '0),
        .ack_i    (wr_ack  ? wmask : '0),
        .pend_o   (pend),
        .en_o     (en),
        .irq_o    (irq_o)
    );

    always_comb begin
        sel_flags = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (sel_port == CTRL_PORT_W'(p)) sel_flags = flags_all[p];
        end
    end

    always_comb begin
        snap_d = snap_q;
        if (wr_ctrl) begin
            if (bus_wdata_i[CTRL_OVF_BIT]) begin
                snap_d.lo = DATA_W'(sel_flags);
                snap_d.hi = '0;
            end else if (bus_wdata_i[CTRL_RDEN_BIT]) begin
                snap_d.lo = pick_lo;
                snap_d.hi = pick_hi;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) snap_q <= '0;
        else         snap_q <= snap_d;
    end

    always_comb begin
        case (bus_addr_i)
            REG_LO:    bus_rdata_o = snap_q.lo;
            REG_HI:    bus_rdata_o = snap_q.hi;
            REG_IEN:   bus_rdata_o = DATA_W'(en);
            REG_ISTAT: bus_rdata_o = DATA_W'(pend);
            default:   bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/stats_bank_chk.sv
module stats_bank_chk
    import stats_pkg::*;
#(
    parameter int NPORTS = 18,
    parameter int NCNT   = 17
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic                          bus_wr_i,
    input logic [2:0]                    bus_addr_i,
    input logic [DATA_W-1:0]             bus_wdata_i,
    input logic                          irq_o,
    input logic [NPORTS-1:0]             pend,
    input logic [NPORTS-1:0]             en,
    input logic [NPORTS-1:0]             wrap_port,
    input logic [NPORTS*NCNT-1:0]        wrap_all,
    input logic [NPORTS*NCNT-1:0]        flags_flat,
    input logic [2*DATA_W-1:0]           snap_flat
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr_i && (bus_addr_i == REG_CTRL);

    AST_PEND_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|wrap_port) |=> ((pend & $past(wrap_port)) == $past(wrap_port))); // R7

    AST_FLAG_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|wrap_all) |=> ((flags_flat & $past(wrap_all)) == $past(wrap_all))); // R2

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (|(pend & en))); // R9

    AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_wr |=> $stable(snap_flat)); // R6

    AST_DIS_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == REG_IDIS)
        |=> ((en & $past(bus_wdata_i[NPORTS-1:0])) == '0)); // R8

    if (NCNT % LANES == 1) begin : g_tail
        AST_TAIL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ctrl_wr && bus_wdata_i[CTRL_RDEN_BIT] && !bus_wdata_i[CTRL_OVF_BIT]
             && bus_wdata_i[CTRL_GRP_LSB +: CTRL_GRP_W] == CTRL_GRP_W'(NCNT / LANES))
            |=> (snap_flat[DATA_W-1:LANE_W] == '0
                 && snap_flat[2*DATA_W-1:DATA_W+LANE_W] == '0)); // R4
    end
endmodule

bind stats_bank stats_bank_chk #(.NPORTS(NPORTS), .NCNT(NCNT)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .pend        (pend),
    .en          (en),
    .wrap_port   (wrap_port),
    .wrap_all    (wrap_all),
    .flags_flat  (flags_all),
    .snap_flat   (snap_q)
);

// File: tb/stats_bank_test.sv
module stats_bank_test;
    localparam int NP     = 18;
    localparam int NC     = 17;
    localparam int CLK_NS = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP*NC-1:0]  ev = '0;
    logic              bus_wr = 1'b0;
    logic [2:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [15:0]   mc [NP][NC];
    logic [NC-1:0] mf [NP];
    logic [NP-1:0] mpend = '0, men = '0;
    logic [31:0]   mlo = '0, mhi = '0;

    always #(CLK_NS/2) clk = ~clk;

    stats_bank #(.NPORTS(NP), .NCNT(NC)) uut (
        .clk_i(clk), .rst_ni(rst_n), .ev_i(ev), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_wr = 1'b0;
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // one clock: drive, predict from pre-edge model, advance
    task automatic tick(input logic [NP*NC-1:0] e, input logic w,
                        input logic [2:0] a, input logic [31:0] d);
        logic [15:0]   nc [NP][NC];
        logic [NC-1:0] nf [NP];
        logic [NC-1:0] wb;
        logic [NP-1:0] wp;
        logic [31:0]   nlo, nhi;
        int            pt, gr;
        ev = e; bus_wr = w; bus_addr = a; bus_wdata = d;
        pt = int'(d[15:8]); gr = int'(d[7:4]);
        nlo = mlo; nhi = mhi; wp = '0;
        if (w && a == 3'd0) begin
            if (d[1]) begin
                nlo = (pt < NP) ? 32'(mf[pt]) : 32'h0;
                nhi = '0;
            end else if (d[0]) begin
                nlo = '0; nhi = '0;
                for (int l = 0; l < 4; l++) begin
                    if (pt < NP && gr*4+l < NC) begin
                        nlo[l*8 +: 8] = mc[pt][gr*4+l][7:0];
                        nhi[l*8 +: 8] = mc[pt][gr*4+l][15:8];
                    end
                end
            end
        end
        for (int p = 0; p < NP; p++) begin
            wb = '0;
            for (int c = 0; c < NC; c++) begin
                nc[p][c] = mc[p][c];
                if (e[p*NC+c]) begin
                    if (mc[p][c] == 16'hFFFF) wb[c] = 1'b1;
                    nc[p][c] = mc[p][c] + 16'd1;
                end
            end
            nf[p] = ((w && a == 3'd0 && d[1] && pt == p) ? '0 : mf[p]) | wb;
            wp[p] = |wb;
        end
        @(posedge clk);
        mc = nc; mf = nf; mlo = nlo; mhi = nhi;
        mpend = (mpend & ~((w && a == 3'd5) ? d[NP-1:0] : '0)) | wp;
        if (w && a == 3'd3) men = men | d[NP-1:0];
        if (w && a == 3'd4) men = men & ~d[NP-1:0];
        @(negedge clk);
        bus_wr = 1'b0; ev = '0;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(3'd1, v); chk({tag, " lo"}, v, mlo);
        rd(3'd2, v); chk({tag, " hi"}, v, mhi);
        rd(3'd3, v); chk({tag, " ien"}, v, 32'(men));
        rd(3'd5, v); chk({tag, " istat"}, v, 32'(mpend));
        chk({tag, " irq"}, 32'(irq), 32'(|(mpend & men)));
    endtask

    function automatic logic [NP*NC-1:0] one(input int p, input int c);
        logic [NP*NC-1:0] r = '0;
        r[p*NC+c] = 1'b1;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R10 watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [NP*NC-1:0] e;
        void'($urandom(32'd1234));
        for (int p = 0; p < NP; p++) begin
            mf[p] = '0;
            for (int c = 0; c < NC; c++) mc[p][c] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: every register reads zero out of reset
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v); chk("R10 reset read", v, 32'h0);
        end
        chk("R10 reset irq", 32'(irq), 32'h0);

        // R8: enable all ports
        tick('0, 1'b1, 3'd3, 32'(~18'h0));
        check_all("R8 enable");

        // R1 R3 R6: random traffic with random snapshots
        for (int n = 0; n < 400; n++) begin
            e = '0;
            for (int i = 0; i < NP*NC; i++) e[i] = ($urandom_range(0, 3) == 0);
            if (n % 7 == 3)
                tick(e, 1'b1, 3'd0, {16'h0, 8'($urandom_range(0, 19)),
                                     4'($urandom_range(0, 5)), 2'b00,
                                     2'($urandom_range(1, 3))});
            else
                tick(e, 1'b0, 3'd0, 32'h0);
            check_all("R1 R3 R6 random");
        end

        // ramp chosen counters to 0xFFFF (R1)
        forever begin
            e = '0;
            if (mc[3][1]  != 16'hFFFF) e |= one(3, 1);
            if (mc[3][16] != 16'hFFFF) e |= one(3, 16);
            if (mc[5][0]  != 16'hFFFF) e |= one(5, 0);
            if (mc[6][0]  != 16'hFFFF) e |= one(6, 0);
            if (e == '0) break;
            tick(e, 1'b0, 3'd0, 32'h0);
        end
        // R4: group 4 of port 3, lanes 1..3 zero
        tick('0, 1'b1, 3'd0, {16'h0, 8'd3, 4'd4, 4'b0001});
        check_all("R4 group4");
        chk("R4 group4 lane0", mlo, 32'h0000_00FF);

        // R2 R7 R9: wrap on port 3
        tick(one(3, 1) | one(3, 16), 1'b0, 3'd0, 32'h0);
        check_all("R2 R7 R9 wrap");
        chk("R7 istat bit3", 32'(mpend), 32'h8);
        tick('0, 1'b1, 3'd0, {16'h0, 8'd3, 4'd0, 4'b0001});
        check_all("R2 count zero");
        chk("R2 lane1 zero", mlo & 32'h0000_FF00, 32'h0);

        // R5: fetch and clear flags
        tick('0, 1'b1, 3'd0, {16'h0, 8'd3, 4'd0, 4'b0011});
        check_all("R5 flags");
        chk("R5 flag bits", mlo, 32'h0001_0002);
        tick('0, 1'b1, 3'd0, {16'h0, 8'd3, 4'd0, 4'b0010});
        check_all("R5 flags cleared");

        // R8 R9: disable then acknowledge
        tick('0, 1'b1, 3'd4, 32'h8);
        check_all("R8 R9 disable");
        tick('0, 1'b1, 3'd5, 32'h8);
        check_all("R8 ack");

        // R5: wrap in the same cycle as the flag fetch
        tick(one(5, 0), 1'b1, 3'd0, {16'h0, 8'd5, 4'd0, 4'b0010});
        check_all("R5 collide");
        tick('0, 1'b1, 3'd0, {16'h0, 8'd5, 4'd0, 4'b0010});
        check_all("R5 kept flag");
        chk("R5 kept bit0", mlo, 32'h1);

        // R8: wrap beats acknowledge on port 6
        tick(one(6, 0), 1'b1, 3'd5, 32'h40 | 32'h20);
        check_all("R8 collide");
        chk("R8 bit6 stays", 32'(mpend) & 32'h40, 32'h40);

        // R4: nonexistent port and group
        tick('0, 1'b1, 3'd0, {16'h0, 8'd20, 4'd0, 4'b0001});
        check_all("R4 bad port");
        tick('0, 1'b1, 3'd0, {16'h0, 8'd0, 4'd7, 4'b0001});
        check_all("R4 bad group");

        // R6: snapshot held while its counters keep moving
        tick('0, 1'b1, 3'd0, {16'h0, 8'd2, 4'd1, 4'b0001});
        for (int n = 0; n < 20; n++) begin
            tick(one(2, 4) | one(2, 5), 1'b0, 3'd0, 32'h0);
            check_all("R6 hold");
        end
        tick('0, 1'b1, 3'd0, {16'h0, 8'd2, 4'd1, 4'b0001});
        check_all("R1 R6 new snapshot");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule